// File: doc/BRIEF.md
# Power-Good Qualifier with Transition Blanking

This block produces the power-good request of a voltage regulator. Each clock it compares a digital sample of the output voltage against a tolerance band derived from a programmable nominal code. The out-of-band result passes through a symmetric deglitch filter, and the filtered result drives a registered pull-low request for an open-drain power-good pin. A request of 1 means the pin is pulled low. A request of 0 means the pin is released to high impedance; the block never drives it high.

During an output-voltage transition the band check can be blanked, so that the expected excursion does not reach the pin. Six device-level conditions override the band result and hold the pin low: thermal shutdown, converter disabled, input undervoltage, input overvoltage, soft start and hiccup. While any of them is present, the filter is held in its fault state. Once they clear, a full deglitch period of good samples is needed before the pin is released.

Top module: `pg_qualifier`

## Requirements
- R1: The low bound is floor(nom_code*19/20). A sample strictly below it is out of band, and a sample equal to it is in band.
- R2: The high bound is floor(nom_code*21/20). A sample strictly above it is out of band, and a sample equal to it is in band.
- R3: An out-of-band condition must be present on DEGLITCH_CYC consecutive clock edges before pg_pull_low goes to 1. A shorter excursion leaves pg_pull_low at 0.
- R4: Release follows the same rule: the filtered state returns to good only after DEGLITCH_CYC consecutive in-band edges. Any reversal restarts the count.
- R5: When blank_dvs_en=1 and dvs_active=1, the band result is ignored and treated as in band. An excursion then leaves pg_pull_low at 0.
- R6: When blank_dvs_en=0, an excursion with dvs_active=1 is filtered like any other excursion and sets pg_pull_low to 1.
- R7: Each of tsd_flag=1, enable=0, uvlo_flag=1, ovlo_flag=1, soft_start=1 and hiccup=1 sets pg_pull_low to 1 at the next clock edge, whatever the sample.
- R8: After every forcing condition clears, pg_pull_low stays 1 until DEGLITCH_CYC in-band edges have passed. It then goes to 0 one edge later.
- R9: While rst_n is low, pg_pull_low is 1, and the filter holds the fault state with its count cleared.
- R10: pg_pull_low is a register. It changes only at a rising clock edge and never in response to an input change between edges.
- R11: With no forcing condition and a good filtered state, pg_pull_low is 0 (released, not driven high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vout_code | input | VW | Sampled output-voltage code |
| nom_code | input | VW | Nominal output-voltage code |
| blank_dvs_en | input | 1 | 1: ignore the band check during a transition |
| dvs_active | input | 1 | Output-voltage transition in progress |
| tsd_flag | input | 1 | Thermal shutdown active |
| enable | input | 1 | Converter enabled (0 forces pull-low) |
| uvlo_flag | input | 1 | Input undervoltage lockout |
| ovlo_flag | input | 1 | Input overvoltage lockout |
| soft_start | input | 1 | Soft start in progress |
| hiccup | input | 1 | Hiccup overcurrent mode active |
| pg_pull_low | output | 1 | 1: pull power-good low; 0: release (high impedance) |

## Verification
Two cases are the hardest to reach from the ports. The first is a count restart inside the deglitch window: an excursion shorter than the window, a single good sample, then a second short excursion, arranged so that the total time out of band exceeds the window while no single run does. The second is the release that follows a forcing condition. The stimulus raises each forcing flag in turn while the sample is in band, then checks the pin both partway through the deglitch window and after it. A behavioural model tracks run lengths and thresholds, and the pin is compared against it on every clock.

// File: rtl/pg_qual_pkg.sv
package pg_qual_pkg;

   // Device-level conditions that hold the power-good pin low.
   typedef struct packed {
      logic therm_sd;
      logic disabled;
      logic vin_low;
      logic vin_high;
      logic ramping;
      logic hiccup;
   } pg_force_t;

   localparam int unsigned PG_FORCE_N = $bits(pg_force_t);

   // Band fractions: low = 19/20, high = 21/20 of nominal.
   localparam int unsigned PG_LO_NUM = 19;
   localparam int unsigned PG_HI_NUM = 21;
   localparam int unsigned PG_DEN    = 20;

endpackage

// File: rtl/pg_win_cmp.sv
module pg_win_cmp #(
   parameter int unsigned VW     = 10,
   parameter int unsigned LO_NUM = 19,
   parameter int unsigned HI_NUM = 21,
   parameter int unsigned DEN    = 20
) (
   input  logic [VW-1:0] vout,
   input  logic [VW-1:0] nom,
   input  logic          blank_en,
   input  logic          dvs_active,
   output logic          eff_fault
);
   localparam int unsigned PW = VW + $clog2(HI_NUM + 1);

   logic [PW-1:0] nom_w;
   logic [PW-1:0] v_w;
   logic [PW-1:0] lo_th;
   logic [PW-1:0] hi_th;
   logic          below;
   logic          above;
   logic          blanked;

   always_comb begin
      nom_w   = PW'(nom);
      v_w     = PW'(vout);
      lo_th   = (nom_w * PW'(LO_NUM)) / PW'(DEN);
      hi_th   = (nom_w * PW'(HI_NUM)) / PW'(DEN);
      below   = v_w < lo_th;
      above   = v_w > hi_th;
      blanked = blank_en & dvs_active;
      eff_fault = (below | above) & ~blanked;
   end
endmodule

// File: rtl/pg_force_or.sv
module pg_force_or #(
   parameter int unsigned N = 6
) (
   input  logic [N-1:0] flags,
   output logic         any
);
   logic [N:0] chain;
   assign chain[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_or
      assign chain[i+1] = chain[i] | flags[i];
   end
   assign any = chain[N];
endmodule

// File: rtl/pg_deglitch.sv
module pg_deglitch #(
   parameter int unsigned DEGLITCH_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic din,
   output logic dout
);
   localparam int unsigned CW = (DEGLITCH_CYC < 2) ? 1 : $clog2(DEGLITCH_CYC);
   localparam logic [CW-1:0] LAST = CW'(DEGLITCH_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b1;
         cnt_q  <= '0;
      end else if (hold) begin
         filt_q <= 1'b1;
         cnt_q  <= '0;
      end else if (din == filt_q) begin
         cnt_q  <= '0;
      end else if (cnt_q == LAST) begin
         filt_q <= din;
         cnt_q  <= '0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign dout = filt_q;
endmodule

// File: rtl/pg_qualifier.sv
module pg_qualifier #(
   parameter int unsigned VW           = 10,
   parameter int unsigned DEGLITCH_CYC = 5000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] vout_code,
   input  logic [VW-1:0] nom_code,
   input  logic          blank_dvs_en,
   input  logic          dvs_active,
   input  logic          tsd_flag,
   input  logic          enable,
   input  logic          uvlo_flag,
   input  logic          ovlo_flag,
   input  logic          soft_start,
   input  logic          hiccup,
   output logic          pg_pull_low
);
   import pg_qual_pkg::*;

   if (VW < 2) begin : g_bad_vw
      $error("pg_qualifier: VW must be at least 2");
   end
   if (VW > 24) begin : g_bad_vw_hi
      $error("pg_qualifier: VW above 24 overflows threshold arithmetic");
   end
   if (DEGLITCH_CYC < 1) begin : g_bad_dg
      $error("pg_qualifier: DEGLITCH_CYC must be at least 1");
   end

   pg_force_t force_vec;
   logic      force_any;
   logic      eff_fault;
   logic      filt_q;

   always_comb begin
      force_vec.therm_sd = tsd_flag;
      force_vec.disabled = ~enable;
      force_vec.vin_low  = uvlo_flag;
      force_vec.vin_high = ovlo_flag;
      force_vec.ramping  = soft_start;
      force_vec.hiccup   = hiccup;
   end

   pg_force_or #(.N(PG_FORCE_N)) u_force (
      .flags (force_vec),
      .any   (force_any)
   );

   pg_win_cmp #(
      .VW     (VW),
      .LO_NUM (PG_LO_NUM),
      .HI_NUM (PG_HI_NUM),
      .DEN    (PG_DEN)
   ) u_win (
      .vout       (vout_code),
      .nom        (nom_code),
      .blank_en   (blank_dvs_en),
      .dvs_active (dvs_active),
      .eff_fault  (eff_fault)
   );

   pg_deglitch #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_dg (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (force_any),
      .din   (eff_fault),
      .dout  (filt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg_pull_low <= 1'b1;
      else        pg_pull_low <= force_any | filt_q;
   end
endmodule

// File: rtl/pg_qualifier_chk.sv
module pg_qualifier_chk #(
   parameter int unsigned DEGLITCH_CYC = 5000
) (
   input logic clk,
   input logic rst_n,
   input logic force_any,
   input logic eff_fault,
   input logic filt_q,
   input logic blank_dvs_en,
   input logic dvs_active,
   input logic pg_pull_low
);
   localparam int unsigned RW = $clog2(DEGLITCH_CYC + 2);

   // Consecutive non-forced in-band edges, saturating.
   logic [RW-1:0] good_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        good_run <= '0;
      else if (force_any || eff_fault)   good_run <= '0;
      else if (good_run < RW'(DEGLITCH_CYC)) good_run <= good_run + 1'b1;
   end

   assert_reset_R9: assert property (@(posedge clk) !rst_n |=> pg_pull_low);

   assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
      force_any |=> pg_pull_low);

   assert_no_quick_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!filt_q && !force_any && !eff_fault) |=> !filt_q);

   assert_no_quick_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_q && (force_any || eff_fault)) |=> filt_q);

   assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!filt_q && blank_dvs_en && dvs_active && !force_any) |=> !filt_q);

   assert_full_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(filt_q) |-> (good_run >= RW'(DEGLITCH_CYC)));

   assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!force_any && !filt_q) |=> !pg_pull_low);
endmodule

bind pg_qualifier pg_qualifier_chk #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .force_any    (force_any),
   .eff_fault    (eff_fault),
   .filt_q       (filt_q),
   .blank_dvs_en (blank_dvs_en),
   .dvs_active   (dvs_active),
   .pg_pull_low  (pg_pull_low)
);

// File: tb/pg_qualifier_tb.sv
module pg_qualifier_tb;
   localparam int VW = 10;
   localparam int DG = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [VW-1:0] vout_code = '0;
   logic [VW-1:0] nom_code = '0;
   logic          blank_dvs_en = 1'b0;
   logic          dvs_active = 1'b0;
   logic          tsd_flag = 1'b0;
   logic          enable = 1'b1;
   logic          uvlo_flag = 1'b0;
   logic          ovlo_flag = 1'b0;
   logic          soft_start = 1'b0;
   logic          hiccup = 1'b0;
   logic          pg_pull_low;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   string cur_req = "R9";

   always #4 clk = ~clk;

   pg_qualifier #(.VW(VW), .DEGLITCH_CYC(DG)) u_dut (
      .clk(clk), .rst_n(rst_n), .vout_code(vout_code), .nom_code(nom_code),
      .blank_dvs_en(blank_dvs_en), .dvs_active(dvs_active), .tsd_flag(tsd_flag),
      .enable(enable), .uvlo_flag(uvlo_flag), .ovlo_flag(ovlo_flag),
      .soft_start(soft_start), .hiccup(hiccup), .pg_pull_low(pg_pull_low)
   );

   // Behavioural reference: run length of disagreeing samples.
   int m_filt = 1;
   int m_run  = 0;
   int m_pl   = 1;

   function automatic int eff_bad();
      int lo, hi, v;
      lo = (int'(nom_code) * 19) / 20;
      hi = (int'(nom_code) * 21) / 20;
      v  = int'(vout_code);
      if (blank_dvs_en && dvs_active) return 0;
      return (v < lo || v > hi) ? 1 : 0;
   endfunction

   function automatic int forced();
      return (tsd_flag || !enable || uvlo_flag || ovlo_flag || soft_start || hiccup) ? 1 : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_filt = 1; m_run = 0; m_pl = 1;
      end else begin
         m_pl = (forced() != 0 || m_filt != 0) ? 1 : 0;
         if (forced() != 0) begin
            m_filt = 1; m_run = 0;
         end else if (eff_bad() == m_filt) begin
            m_run = 0;
         end else begin
            m_run++;
            if (m_run == DG) begin
               m_filt = eff_bad(); m_run = 0;
            end
         end
      end
   end

   // Per-cycle comparison, well after the edge.
   always @(posedge clk) begin
      #2;
      if (!done) begin
         checks++;
         if (int'(pg_pull_low) != m_pl) begin
            failures++;
            $display("FAIL %s cycle compare: actual=%0d expected=%0d at %0t",
                     cur_req, pg_pull_low, m_pl, $time);
         end
      end
   end

   task automatic expect_pl(input string req, input logic exp);
      checks++;
      if (pg_pull_low !== exp) begin
         failures++;
         $display("FAIL %s directed: actual=%0b expected=%0b at %0t",
                  req, pg_pull_low, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic settle_good();
      vout_code = 10'd400; blank_dvs_en = 1'b0; dvs_active = 1'b0;
      cyc(DG + 4);
   endtask

   task automatic force_case(input int which, input string req);
      cur_req = req;
      case (which)
         0: tsd_flag = 1'b1;
         1: enable = 1'b0;
         2: uvlo_flag = 1'b1;
         3: ovlo_flag = 1'b1;
         4: soft_start = 1'b1;
         default: hiccup = 1'b1;
      endcase
      cyc(1);
      expect_pl("R7", 1'b1);
      cyc(2);
      tsd_flag = 1'b0; enable = 1'b1; uvlo_flag = 1'b0;
      ovlo_flag = 1'b0; soft_start = 1'b0; hiccup = 1'b0;
      cyc(DG - 2);
      expect_pl("R8", 1'b1);
      cyc(4);
      expect_pl("R8", 1'b0);
   endtask

   initial begin
      nom_code = 10'd400;   // band 380..420
      vout_code = 10'd400;
      cyc(3);
      expect_pl("R9", 1'b1);
      rst_n = 1'b1;
      cur_req = "R4";
      cyc(3);
      expect_pl("R4", 1'b1);
      cyc(DG + 2);
      expect_pl("R11", 1'b0);

      cur_req = "R3";
      vout_code = 10'd379; cyc(DG - 2);
      vout_code = 10'd400; cyc(2);
      expect_pl("R3", 1'b0);

      cur_req = "R1";
      vout_code = 10'd380; cyc(DG + 4);
      expect_pl("R1", 1'b0);
      vout_code = 10'd379; cyc(DG + 2);
      expect_pl("R1", 1'b1);
      settle_good();
      expect_pl("R4", 1'b0);

      cur_req = "R2";
      vout_code = 10'd420; cyc(DG + 4);
      expect_pl("R2", 1'b0);
      vout_code = 10'd421; cyc(DG + 2);
      expect_pl("R2", 1'b1);

      cur_req = "R4";
      vout_code = 10'd400; cyc(DG - 2);
      vout_code = 10'd421; cyc(1);
      vout_code = 10'd400; cyc(DG - 2);
      expect_pl("R4", 1'b1);
      cyc(4);
      expect_pl("R4", 1'b0);

      cur_req = "R3";
      vout_code = 10'd379; cyc(DG - 2);
      vout_code = 10'd400; cyc(1);
      vout_code = 10'd379; cyc(DG - 2);
      expect_pl("R3", 1'b0);
      settle_good();

      cur_req = "R5";
      blank_dvs_en = 1'b1; dvs_active = 1'b1; vout_code = 10'd300;
      cyc(DG + 4);
      expect_pl("R5", 1'b0);
      vout_code = 10'd500; cyc(DG + 4);
      expect_pl("R5", 1'b0);
      settle_good();

      cur_req = "R6";
      blank_dvs_en = 1'b0; dvs_active = 1'b1; vout_code = 10'd300;
      cyc(DG + 2);
      expect_pl("R6", 1'b1);
      settle_good();
      expect_pl("R6", 1'b0);

      for (int k = 0; k < 6; k++) force_case(k, "R7");

      // R10: an input change between edges does not reach the pin.
      cur_req = "R10";
      #1 soft_start = 1'b1;
      #1 expect_pl("R10", 1'b0);
      cyc(2);
      expect_pl("R10", 1'b1);
      soft_start = 1'b0;
      settle_good();

      // New nominal: band 190..210, sample 400 is out of band (R2).
      cur_req = "R2";
      nom_code = 10'd200; cyc(DG + 2);
      expect_pl("R2", 1'b1);
      vout_code = 10'd190; cyc(DG + 3);
      expect_pl("R1", 1'b0);

      // R9: reset mid-operation returns the pin low.
      cur_req = "R9";
      rst_n = 1'b0; cyc(1);
      expect_pl("R9", 1'b1);
      rst_n = 1'b1; cyc(3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule